// File: doc/BRIEF.md
# Configuration Status and Revision Register Pair

This block holds the 16-bit status half-word of a host bus configuration header together with an 8-bit silicon revision code. Two agents reach it through identical dword-wide access ports: the host configuration side and a local processor side. Each port carries a write strobe, a byte address, four byte enables and write data, and gets back the addressed dword combinationally.

The bus interface logic reports events to the block as single-cycle strobes. These cover parity trouble, aborts and system error signalling. The block latches each strobe into a sticky flag. Software clears a flag by writing a 1 to its position. One flag sets only when the parity-error-response enable from the command register is on. Another flag sets on any detected parity error, whatever the enable says. A user feature bit may be changed from the local side only. The revision code can be loaded by a local write or by a strobe from the nonvolatile-memory loader, and the host side can only read it.

Top module: `pci_stat_reg`

## Requirements
- R1: After reset, dword 04h reads 0x0280_0000 on both ports (status 0x0280) and dword 08h reads the REV_INIT value in bits 7:0.
- R2: Status bits 5:0 always read 0, bit 7 always reads 1 and bits 10:9 always read 01. Writes from either port to these bits have no effect.
- R3: Status bit 6 takes the written value only from a local-port write to dword 04h with byte enable 2 active (data bit 22). Host writes leave it unchanged.
- R4: Status bit 8 sets only when the PERR strobe, the bus-master indication and the parity-error-response enable are all 1 in the same cycle.
- R5: Status bits 11, 12, 13 and 14 set on the signaled-target-abort, received-target-abort, master-abort and SERR strobes respectively.
- R6: Status bit 15 sets on an address-phase parity error, a target-write data parity error or a master-read data parity error, regardless of the parity-error-response enable.
- R7: A write of 1 from either port clears status bits 8 and 11 to 15 (status bit n sits at dword bit n+16). Writing 0 leaves them unchanged.
- R8: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: Status writes are gated per byte lane. Byte enable 2 covers status bits 7:0 and byte enable 3 covers status bits 15:8. Writes to any dword other than 04h leave the status unchanged.
- R10: The revision code (dword 08h, bits 7:0) is loaded by a local write with byte enable 0 or by the load strobe. The load strobe wins when both occur in one cycle. Host writes leave it unchanged.
- R11: Bits 15:0 of dword 04h, bits 31:8 of dword 08h, and every other dword read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host-side write strobe |
| host_addr_i | input | 8 | Host-side byte address |
| host_be_i | input | 4 | Host-side byte enables |
| host_wdata_i | input | 32 | Host-side write data |
| host_rdata_o | output | 32 | Host-side read data for host_addr_i |
| loc_wr_i | input | 1 | Local-side write strobe |
| loc_addr_i | input | 8 | Local-side byte address |
| loc_be_i | input | 4 | Local-side byte enables |
| loc_wdata_i | input | 32 | Local-side write data |
| loc_rdata_o | output | 32 | Local-side read data for loc_addr_i |
| perr_i | input | 1 | PERR driven or observed |
| bus_master_i | input | 1 | Device was master of the transfer |
| perr_resp_en_i | input | 1 | Parity-error-response enable from the command register |
| sig_tabort_i | input | 1 | Target abort signaled |
| rcv_tabort_i | input | 1 | Target abort received |
| mabort_i | input | 1 | Master abort generated |
| serr_i | input | 1 | SERR asserted |
| addr_perr_i | input | 1 | Address-phase parity error |
| tgt_wr_perr_i | input | 1 | Data parity error as target of a write |
| mst_rd_perr_i | input | 1 | Data parity error on a master read |
| rev_load_i | input | 1 | Revision load strobe from the memory loader |
| rev_load_val_i | input | 8 | Revision value to load |

## Verification
Three kinds of action can hit the same status or revision bit in one clock: an event strobe, a host write-1-to-clear and a local write-1-to-clear. For the revision code, a local write can meet a load strobe. The bench drives such collisions on purpose, for example SERR together with a clearing host write to bit 14, and a load strobe together with a local write to dword 08h. It then checks that the event or the strobe wins. A behavioural reference model is stepped on every clock and compared on both read ports.

// File: rtl/pci_stat_pkg.sv
package pci_stat_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned ST_W   = 16;
  localparam int unsigned REV_W  = 8;
  localparam int unsigned DW_W   = 6;

  localparam logic [DW_W-1:0] STAT_DW = 6'h01;
  localparam logic [DW_W-1:0] REV_DW  = 6'h02;

  localparam int unsigned UDF_BIT  = 6;
  localparam int unsigned MDPE_BIT = 8;
  localparam int unsigned STA_BIT  = 11;
  localparam int unsigned RTA_BIT  = 12;
  localparam int unsigned RMA_BIT  = 13;
  localparam int unsigned SSE_BIT  = 14;
  localparam int unsigned DPE_BIT  = 15;

  localparam logic [ST_W-1:0] W1C_MASK  = 16'hF900;
  localparam logic [ST_W-1:0] FIXED_VAL = 16'h0280;

  typedef struct packed {
    logic              wr;
    logic [DW_W-1:0]   dw;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/pci_stat_port_dec.sv
module pci_stat_port_dec
  import pci_stat_pkg::*;
#(
  parameter bit LOCAL_SIDE = 1'b0
) (
  input  cfg_req_t         req_i,
  output logic [ST_W-1:0]  clr_o,
  output logic             udf_we_o,
  output logic             udf_val_o,
  output logic             rev_we_o,
  output logic [REV_W-1:0] rev_val_o
);
  localparam int unsigned LANES = ST_W / 8;
  localparam int unsigned LANE0 = (DATA_W - ST_W) / 8;

  logic             stat_hit;
  logic [LANES-1:0] lane_en;
  logic [ST_W-1:0]  lane_bits;

  assign stat_hit = req_i.wr && (req_i.dw == STAT_DW);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = stat_hit && req_i.be[LANE0+g];
    assign lane_bits[g*8 +: 8] = lane_en[g] ? req_i.wdata[(LANE0+g)*8 +: 8] : 8'h00;
  end

  assign clr_o = lane_bits & W1C_MASK;

  if (LOCAL_SIDE) begin : g_local
    assign udf_we_o  = lane_en[UDF_BIT/8];
    assign udf_val_o = req_i.wdata[DATA_W-ST_W+UDF_BIT];
    assign rev_we_o  = req_i.wr && (req_i.dw == REV_DW) && req_i.be[0];
    assign rev_val_o = req_i.wdata[REV_W-1:0];
  end else begin : g_host
    assign udf_we_o  = 1'b0;
    assign udf_val_o = 1'b0;
    assign rev_we_o  = 1'b0;
    assign rev_val_o = '0;
  end

  logic unused_ok;
  assign unused_ok = ^{req_i.wdata, req_i.be};
endmodule

// File: rtl/pci_stat_flags.sv
module pci_stat_flags
  import pci_stat_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] q_o
);
  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    if (W1C_MASK[i]) begin : g_sticky
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;   // event beats clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end

  logic unused_ok;
  assign unused_ok = ^(set_i & ~W1C_MASK) ^ ^(clr_i & ~W1C_MASK);
endmodule

// File: rtl/pci_stat_rev.sv
module pci_stat_rev
  import pci_stat_pkg::*;
#(
  parameter logic [REV_W-1:0] REV_INIT = 8'h02
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REV_W-1:0] load_val_i,
  input  logic             loc_we_i,
  input  logic [REV_W-1:0] loc_val_i,
  output logic [REV_W-1:0] rev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rev_o <= REV_INIT;
    else if (load_i)   rev_o <= load_val_i;
    else if (loc_we_i) rev_o <= loc_val_i;
  end
endmodule

// File: rtl/pci_stat_reg.sv
module pci_stat_reg
  import pci_stat_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 8,
  parameter logic [REV_W-1:0] REV_INIT = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BE_W-1:0]   host_be_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              loc_wr_i,
  input  logic [ADDR_W-1:0] loc_addr_i,
  input  logic [BE_W-1:0]   loc_be_i,
  input  logic [DATA_W-1:0] loc_wdata_i,
  output logic [DATA_W-1:0] loc_rdata_o,
  input  logic              perr_i,
  input  logic              bus_master_i,
  input  logic              perr_resp_en_i,
  input  logic              sig_tabort_i,
  input  logic              rcv_tabort_i,
  input  logic              mabort_i,
  input  logic              serr_i,
  input  logic              addr_perr_i,
  input  logic              tgt_wr_perr_i,
  input  logic              mst_rd_perr_i,
  input  logic              rev_load_i,
  input  logic [REV_W-1:0]  rev_load_val_i
);
  localparam int unsigned NPORT = 2;

  cfg_req_t         req   [NPORT];
  logic [ST_W-1:0]  clr   [NPORT];
  logic             udf_we[NPORT];
  logic             udf_v [NPORT];
  logic             rev_we[NPORT];
  logic [REV_W-1:0] rev_v [NPORT];

  assign req[0] = '{wr: host_wr_i, dw: host_addr_i[DW_W+1:2], be: host_be_i, wdata: host_wdata_i};
  assign req[1] = '{wr: loc_wr_i,  dw: loc_addr_i[DW_W+1:2],  be: loc_be_i,  wdata: loc_wdata_i};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pci_stat_port_dec #(.LOCAL_SIDE(p == 1)) u_dec (
      .req_i    (req[p]),
      .clr_o    (clr[p]),
      .udf_we_o (udf_we[p]),
      .udf_val_o(udf_v[p]),
      .rev_we_o (rev_we[p]),
      .rev_val_o(rev_v[p])
    );
  end

  logic [ST_W-1:0] set_vec;
  always_comb begin
    set_vec           = '0;
    set_vec[MDPE_BIT] = perr_i && bus_master_i && perr_resp_en_i;
    set_vec[STA_BIT]  = sig_tabort_i;
    set_vec[RTA_BIT]  = rcv_tabort_i;
    set_vec[RMA_BIT]  = mabort_i;
    set_vec[SSE_BIT]  = serr_i;
    set_vec[DPE_BIT]  = addr_perr_i || tgt_wr_perr_i || mst_rd_perr_i;
  end

  logic [ST_W-1:0] flags;
  pci_stat_flags u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr[0] | clr[1]),
    .q_o   (flags)
  );

  logic udf_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        udf_q <= 1'b0;
    else if (udf_we[1]) udf_q <= udf_v[1];
  end

  logic [REV_W-1:0] rev_q;
  pci_stat_rev #(.REV_INIT(REV_INIT)) u_rev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (rev_load_i),
    .load_val_i(rev_load_val_i),
    .loc_we_i  (rev_we[1]),
    .loc_val_i (rev_v[1]),
    .rev_o     (rev_q)
  );

  logic [ST_W-1:0] status;
  assign status = FIXED_VAL | flags | (ST_W'(udf_q) << UDF_BIT);

  function automatic logic [DATA_W-1:0] rd_mux(input logic [DW_W-1:0] dw);
    case (dw)
      STAT_DW: rd_mux = {status, {(DATA_W-ST_W){1'b0}}};
      REV_DW:  rd_mux = {{(DATA_W-REV_W){1'b0}}, rev_q};
      default: rd_mux = '0;
    endcase
  endfunction

  assign host_rdata_o = rd_mux(req[0].dw);
  assign loc_rdata_o  = rd_mux(req[1].dw);

  logic unused_ok;
  assign unused_ok = ^{host_addr_i[1:0], loc_addr_i[1:0], udf_we[0], udf_v[0],
                       rev_we[0], rev_v[0]};
endmodule

// File: rtl/pci_stat_reg_chk.sv
module pci_stat_reg_chk
  import pci_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ST_W-1:0]   status_i,
  input logic [REV_W-1:0]  rev_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [BE_W-1:0]   host_be_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              loc_wr_i,
  input logic [ADDR_W-1:0] loc_addr_i,
  input logic [BE_W-1:0]   loc_be_i,
  input logic [DATA_W-1:0] loc_wdata_i,
  input logic              perr_i,
  input logic              bus_master_i,
  input logic              perr_resp_en_i,
  input logic              sig_tabort_i,
  input logic              rcv_tabort_i,
  input logic              mabort_i,
  input logic              serr_i,
  input logic              addr_perr_i,
  input logic              tgt_wr_perr_i,
  input logic              mst_rd_perr_i,
  input logic              rev_load_i
);
  logic loc_stat_lane2, loc_rev_wr, any_clr11;
  assign loc_stat_lane2 = loc_wr_i && loc_addr_i[7:2] == STAT_DW && loc_be_i[2];
  assign loc_rev_wr     = loc_wr_i && loc_addr_i[7:2] == REV_DW && loc_be_i[0];
  assign any_clr11 = (host_wr_i && host_addr_i[7:2] == STAT_DW && host_be_i[3] && host_wdata_i[27])
                  || (loc_wr_i && loc_addr_i[7:2] == STAT_DW && loc_be_i[3] && loc_wdata_i[27]);

  a_r2_fixed_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[5:0] == 6'd0 && status_i[7] && status_i[10:9] == 2'b01);
  a_r3_udf_local_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_i[6]) |-> $past(loc_stat_lane2));
  a_r4_mdpe_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_i && bus_master_i && perr_resp_en_i) |=> status_i[8]);
  a_r4_mdpe_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[8]) |-> $past(perr_i && bus_master_i && perr_resp_en_i));
  a_r5_sta_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_tabort_i |=> status_i[11]);
  a_r5_rta_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_tabort_i |=> status_i[12]);
  a_r5_rma_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mabort_i |=> status_i[13]);
  a_r5_sse_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_i |=> status_i[14]);
  a_r6_dpe_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_perr_i || tgt_wr_perr_i || mst_rd_perr_i) |=> status_i[15]);
  a_r7_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_i[11]) |-> $past(any_clr11));
  a_r10_rev_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rev_i) |-> $past(rev_load_i || loc_rev_wr));
endmodule

bind pci_stat_reg pci_stat_reg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status), .rev_i(rev_q),
  .host_wr_i(host_wr_i), .host_addr_i(host_addr_i), .host_be_i(host_be_i),
  .host_wdata_i(host_wdata_i), .loc_wr_i(loc_wr_i), .loc_addr_i(loc_addr_i),
  .loc_be_i(loc_be_i), .loc_wdata_i(loc_wdata_i), .perr_i(perr_i),
  .bus_master_i(bus_master_i), .perr_resp_en_i(perr_resp_en_i),
  .sig_tabort_i(sig_tabort_i), .rcv_tabort_i(rcv_tabort_i), .mabort_i(mabort_i),
  .serr_i(serr_i), .addr_perr_i(addr_perr_i), .tgt_wr_perr_i(tgt_wr_perr_i),
  .mst_rd_perr_i(mst_rd_perr_i), .rev_load_i(rev_load_i)
);

// File: tb/tb_pci_stat_reg.sv
module tb_pci_stat_reg;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [7:0]  REV_INIT   = 8'h02;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_wr_i, loc_wr_i;
  logic [7:0] host_addr_i, loc_addr_i;
  logic [3:0] host_be_i, loc_be_i;
  logic [31:0] host_wdata_i, loc_wdata_i, host_rdata_o, loc_rdata_o;
  logic perr_i, bus_master_i, perr_resp_en_i, sig_tabort_i, rcv_tabort_i;
  logic mabort_i, serr_i, addr_perr_i, tgt_wr_perr_i, mst_rd_perr_i, rev_load_i;
  logic [7:0] rev_load_val_i;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pci_stat_reg #(.ADDR_W(8), .REV_INIT(REV_INIT)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] m_st = 16'h0280;
  logic [7:0]  m_rev = REV_INIT;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a[7:2])
      6'h01:   return {m_st, 16'h0000};
      6'h02:   return {24'h0, m_rev};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (host_rdata_o !== exp_rd(host_addr_i)) begin
      n_fail++;
      $display("FAIL %s host @%h: got %h exp %h", tag, host_addr_i, host_rdata_o, exp_rd(host_addr_i));
    end
    n_chk++;
    if (loc_rdata_o !== exp_rd(loc_addr_i)) begin
      n_fail++;
      $display("FAIL %s local @%h: got %h exp %h", tag, loc_addr_i, loc_rdata_o, exp_rd(loc_addr_i));
    end
  endtask

  task automatic idle();
    host_wr_i = 0; host_addr_i = 8'h04; host_be_i = 0; host_wdata_i = 0;
    loc_wr_i = 0; loc_addr_i = 8'h08; loc_be_i = 0; loc_wdata_i = 0;
    perr_i = 0; bus_master_i = 0; perr_resp_en_i = 0; sig_tabort_i = 0;
    rcv_tabort_i = 0; mabort_i = 0; serr_i = 0; addr_perr_i = 0;
    tgt_wr_perr_i = 0; mst_rd_perr_i = 0; rev_load_i = 0; rev_load_val_i = 0;
  endtask

  // behavioural model step, using the inputs held across the edge
  task automatic model_step();
    logic [15:0] wipe = 16'h0;
    int w1c[6] = '{8, 11, 12, 13, 14, 15};
    bit ev[6];
    if (host_wr_i && host_addr_i[7:2] == 6'h01) begin
      if (host_be_i[2]) wipe[7:0]  |= host_wdata_i[23:16];
      if (host_be_i[3]) wipe[15:8] |= host_wdata_i[31:24];
    end
    if (loc_wr_i && loc_addr_i[7:2] == 6'h01) begin
      if (loc_be_i[2]) begin wipe[7:0] |= loc_wdata_i[23:16]; m_st[6] = loc_wdata_i[22]; end
      if (loc_be_i[3]) wipe[15:8] |= loc_wdata_i[31:24];
    end
    ev = '{perr_i & bus_master_i & perr_resp_en_i, sig_tabort_i, rcv_tabort_i,
           mabort_i, serr_i, addr_perr_i | tgt_wr_perr_i | mst_rd_perr_i};
    foreach (w1c[k]) begin
      if (wipe[w1c[k]]) m_st[w1c[k]] = 1'b0;
      if (ev[k])        m_st[w1c[k]] = 1'b1;
    end
    if (rev_load_i) m_rev = rev_load_val_i;
    else if (loc_wr_i && loc_addr_i[7:2] == 6'h02 && loc_be_i[0]) m_rev = loc_wdata_i[7:0];
  endtask

  task automatic cyc(input string tag);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check(tag);
    idle();
    @(negedge clk_i) ;
    check(tag);
  endtask

  task automatic hwr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    host_wr_i = 1; host_addr_i = a; host_be_i = be; host_wdata_i = d;
  endtask
  task automatic lwr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    loc_wr_i = 1; loc_addr_i = a; loc_be_i = be; loc_wdata_i = d;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check("R1 reset");
    host_addr_i = 8'h08; loc_addr_i = 8'h04; #1 check("R1 reset swapped");

    idle(); hwr(8'h04, 4'hF, 32'hFFFF_FFFF); cyc("R2 host ones");
    lwr(8'h04, 4'hC, 32'h0000_0000); cyc("R2 local zeros");
    hwr(8'h04, 4'h4, 32'h0040_0000); cyc("R3 host udf ignored");
    lwr(8'h04, 4'h4, 32'h0040_0000); cyc("R3 local udf set");
    lwr(8'h04, 4'h4, 32'h0000_0000); cyc("R3 local udf clear");

    perr_i = 1; bus_master_i = 1; cyc("R4 enable off");
    perr_i = 1; perr_resp_en_i = 1; cyc("R4 not master");
    bus_master_i = 1; perr_resp_en_i = 1; cyc("R4 master no perr");
    perr_i = 1; bus_master_i = 1; perr_resp_en_i = 1; cyc("R4 all set");

    sig_tabort_i = 1; cyc("R5 sig tabort");
    rcv_tabort_i = 1; cyc("R5 rcv tabort");
    mabort_i = 1; cyc("R5 mabort");
    serr_i = 1; cyc("R5 serr");

    hwr(8'h04, 4'hC, 32'hFFFF_0000); cyc("R7 host clear all");
    addr_perr_i = 1; cyc("R6 addr perr");
    hwr(8'h04, 4'h8, 32'h8000_0000); cyc("R7 clear bit15");
    tgt_wr_perr_i = 1; perr_resp_en_i = 0; cyc("R6 target write");
    hwr(8'h04, 4'h8, 32'h8000_0000); cyc("R7 clear bit15 again");
    mst_rd_perr_i = 1; cyc("R6 master read");

    sig_tabort_i = 1; rcv_tabort_i = 1; cyc("R5 two at once");
    hwr(8'h04, 4'hC, 32'h0000_0000); cyc("R7 write zeros");
    lwr(8'h04, 4'h8, 32'h1000_0000); cyc("R7 local clear bit12");
    hwr(8'h04, 4'h8, 32'h0800_0000); cyc("R7 host clear bit11");

    serr_i = 1; cyc("R8 set serr");
    serr_i = 1; hwr(8'h04, 4'h8, 32'h4000_0000); cyc("R8 set beats clear");
    mabort_i = 1; lwr(8'h04, 4'h8, 32'h2000_0000); cyc("R8 local race");

    hwr(8'h04, 4'h7, 32'hFFFF_FFFF); cyc("R9 lane3 disabled");
    hwr(8'h08, 4'hF, 32'hFFFF_FFFF); cyc("R9 wrong dword");
    lwr(8'h00, 4'hF, 32'hFFFF_FFFF); cyc("R9 local wrong dword");
    lwr(8'h04, 4'h8, 32'hFF40_0000); cyc("R9 lane2 disabled");
    lwr(8'h04, 4'h4, 32'hFF40_0000); cyc("R9 lane2 only");

    hwr(8'h08, 4'h1, 32'h0000_00A5); cyc("R10 host rev ignored");
    lwr(8'h08, 4'h1, 32'hFFFF_FF3C); cyc("R10 local rev");
    lwr(8'h08, 4'hE, 32'h0000_0077); cyc("R10 local no be0");
    rev_load_i = 1; rev_load_val_i = 8'h5A; cyc("R10 load strobe");
    rev_load_i = 1; rev_load_val_i = 8'hC3; lwr(8'h08, 4'h1, 32'h11); cyc("R10 load wins");

    idle(); host_addr_i = 8'h00; loc_addr_i = 8'h0C; #1 check("R11 other dwords");
    host_addr_i = 8'hFC; loc_addr_i = 8'h06; #1 check("R11 far and offset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule